// File: doc/BRIEF.md
# Dual-Rail Half-Buffer Pipeline

This block is a cycle-level model of a fine-grain dual-rail pipeline. Each stage takes a word on a dual-rail input channel, computes its output rails straight from the input rails with no data register in between, and runs its input and output four-phase handshakes interleaved rather than back to back. Every signal transition of the modelled circuit takes one clock cycle, so latency and cycle time can be read off the ports in transitions.

The word is cut into 8-bit slices. Each slice has its own completion detection for its input and output rails, and all slices of a stage work in parallel. The stage's control combines the slice results into the input acknowledge, and from it produces one enable that goes back out to every slice. A chain of `NSTAGE` such stages sits between an upstream producer and a downstream consumer. Each stage passes a slice through unchanged or inverts it, chosen per slice by a mask parameter.

Top module: `hbuf_pipe`

## Requirements
- R1: After reset, every output rail is low and `in_ack` is low.
- R2: Each bit travels on two rails. `t` high with `f` low means 1, `f` high with `t` low means 0, and both low means empty. At no stage boundary are both rails of a bit high.
- R3: Slice s covers bits 8s+7 to 8s. Each stage passes slice s unchanged when `INV_MASK[s]` is 0 and inverts it when it is 1. The chain applies this `NSTAGE` times.
- R4: When a word is presented before a clock edge to an idle chain, the output is fully valid exactly 2*`NSTAGE` edges later, and it is still empty one edge earlier.
- R5: A stage raises its input acknowledge two cycles after all of its input bits and all of its output bits have become valid. A word that is missing a slice is never acknowledged, although its complete slices still pass through to the output.
- R6: While the output is fully valid and `out_ack` is low, the output rails do not change.
- R7: A stage's enable falls only when its input and output acknowledges are both high, and rises only when both are low. Its input acknowledge falls two cycles after its input and output rails are all empty. For a single stage whose neighbours each respond in one cycle, the output goes empty 5 cycles after it becomes valid, and `in_ack` falls 2 cycles after that.
- R8: A stream of words comes out in order, each word exactly once, with the value that R3 gives.
- R9: A single stage whose neighbours each answer every handshake event within one cycle delivers one word every 10 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one edge models one transition |
| rst_n | input | 1 | Active-low synchronous reset |
| in_t | input | W | True rails of the input word |
| in_f | input | W | False rails of the input word |
| in_ack | output | 1 | Acknowledge of the input channel |
| out_t | output | W | True rails of the output word |
| out_f | output | W | False rails of the output word |
| out_ack | input | 1 | Acknowledge from the consumer |

## Verification
Each stage has three pieces of control state: its enable, its acknowledge and its evaluate nodes. If the enable or the acknowledge is wrong, a handshake edge moves. That shows up within a few cycles as a changed latency, a changed token spacing or a changed delay before `in_ack` falls. If the enable falls too early, or an evaluate node keeps a stale rail, the output carries a wrong or lost word, or a word from which a slice is missing. That shows up at the consumer on the next word, as a value mismatch or as a bit with both rails high. A partial word that is acknowledged, or an output that moves while `out_ack` is low, shows at the ports within a cycle of the fault.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int SLICE_W = 8;

  typedef struct packed {
    logic [SLICE_W-1:0] t;
    logic [SLICE_W-1:0] f;
  } rail_pair_t;

  // per-slice function: a bitwise dual-rail map is a swap of the rails
  function automatic rail_pair_t hb_map(input logic [SLICE_W-1:0] t,
                                        input logic [SLICE_W-1:0] f,
                                        input logic inv);
    rail_pair_t r;
    r.t = inv ? f : t;
    r.f = inv ? t : f;
    return r;
  endfunction

  function automatic logic rails_full(input logic [SLICE_W-1:0] t,
                                      input logic [SLICE_W-1:0] f);
    return &(t | f);
  endfunction

  function automatic logic rails_empty(input logic [SLICE_W-1:0] t,
                                       input logic [SLICE_W-1:0] f);
    return ~|(t | f);
  endfunction

  // one step of a state-holding join: set wins, then clear, else keep
  function automatic logic c_step(input logic set, input logic clr, input logic cur);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/hb_slice.sv
module hb_slice
  import hb_pkg::*;
#(
  parameter bit INV = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [SLICE_W-1:0] in_t,
  input  logic [SLICE_W-1:0] in_f,
  output logic [SLICE_W-1:0] out_t,
  output logic [SLICE_W-1:0] out_f,
  output logic               done,
  output logic               nul
);
  rail_pair_t mapped;
  rail_pair_t eval_q;   // evaluate nodes: set by rails, cleared by precharge

  always_comb mapped = hb_map(in_t, in_f, INV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eval_q <= '0;
      out_t  <= '0;
      out_f  <= '0;
      done   <= 1'b0;
      nul    <= 1'b0;
    end else begin
      if (en) begin
        eval_q.t <= eval_q.t | mapped.t;
        eval_q.f <= eval_q.f | mapped.f;
      end else begin
        eval_q <= '0;
      end
      out_t <= eval_q.t;
      out_f <= eval_q.f;
      done  <= rails_full(in_t, in_f) && rails_full(out_t, out_f);
      nul   <= rails_empty(in_t, in_f) && rails_empty(out_t, out_f);
    end
  end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int NSLICE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSLICE-1:0] done,
  input  logic [NSLICE-1:0] nul,
  input  logic              ra,
  output logic              la,
  output logic              en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      la <= 1'b0;
      en <= 1'b1;
    end else begin
      la <= c_step(&done, &nul, la);
      en <= c_step(!la && !ra, la && ra, en);
    end
  end
endmodule

// File: rtl/hb_stage.sv
module hb_stage
  import hb_pkg::*;
#(
  parameter int                      W        = 32,
  parameter logic [W/SLICE_W-1:0]    INV_MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         la,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         ra,
  output logic         en
);
  localparam int NSLICE = W / SLICE_W;

  logic [NSLICE-1:0] done_v;
  logic [NSLICE-1:0] nul_v;

  for (genvar s = 0; s < NSLICE; s++) begin : g_slice
    hb_slice #(.INV(INV_MASK[s])) u_slice (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en),
      .in_t (in_t[s*SLICE_W +: SLICE_W]),
      .in_f (in_f[s*SLICE_W +: SLICE_W]),
      .out_t(out_t[s*SLICE_W +: SLICE_W]),
      .out_f(out_f[s*SLICE_W +: SLICE_W]),
      .done (done_v[s]),
      .nul  (nul_v[s])
    );
  end

  hb_ctrl #(.NSLICE(NSLICE)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .done (done_v),
    .nul  (nul_v),
    .ra   (ra),
    .la   (la),
    .en   (en)
  );
endmodule

// File: rtl/hbuf_pipe.sv
module hbuf_pipe
  import hb_pkg::*;
#(
  parameter int                   W        = 32,
  parameter int                   NSTAGE   = 3,
  parameter logic [W/SLICE_W-1:0] INV_MASK = 4'b0110
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         in_ack,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         out_ack
);
  // channel k feeds stage k; ack_w[k] is the acknowledge of channel k
  logic [W-1:0] bnd_t [NSTAGE+1];
  logic [W-1:0] bnd_f [NSTAGE+1];
  logic         ack_w [NSTAGE+1];
  logic         en_w  [NSTAGE];

  assign bnd_t[0]      = in_t;
  assign bnd_f[0]      = in_f;
  assign ack_w[NSTAGE] = out_ack;
  assign in_ack        = ack_w[0];
  assign out_t         = bnd_t[NSTAGE];
  assign out_f         = bnd_f[NSTAGE];

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    hb_stage #(.W(W), .INV_MASK(INV_MASK)) u_stage (
      .clk  (clk),
      .rst_n(rst_n),
      .in_t (bnd_t[k]),
      .in_f (bnd_f[k]),
      .la   (ack_w[k]),
      .out_t(bnd_t[k+1]),
      .out_f(bnd_f[k+1]),
      .ra   (ack_w[k+1]),
      .en   (en_w[k])
    );
  end
endmodule

// File: rtl/hbuf_pipe_chk.sv
module hbuf_pipe_chk #(
  parameter int W      = 32,
  parameter int NSTAGE = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bnd_t [NSTAGE+1],
  input logic [W-1:0] bnd_f [NSTAGE+1],
  input logic         ack_w [NSTAGE+1],
  input logic         en_w  [NSTAGE]
);
  for (genvar k = 0; k < NSTAGE; k++) begin : g_chk
    a_r2_rails_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd_t[k+1] & bnd_f[k+1]) == '0);

    a_r5_ack_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack_w[k]) |-> $past((&(bnd_t[k] | bnd_f[k])) && (&(bnd_t[k+1] | bnd_f[k+1])), 2));

    a_r7_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ack_w[k]) |-> $past(!(|(bnd_t[k] | bnd_f[k])) && !(|(bnd_t[k+1] | bnd_f[k+1])), 2));

    a_r7_en_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_w[k]) |-> $past(ack_w[k] && ack_w[k+1]));

    a_r7_en_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_w[k]) |-> $past(!ack_w[k] && !ack_w[k+1]));
  end

  a_r6_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    ((&(bnd_t[NSTAGE] | bnd_f[NSTAGE])) && !ack_w[NSTAGE])
      |=> ($stable(bnd_t[NSTAGE]) && $stable(bnd_f[NSTAGE])));
endmodule

bind hbuf_pipe hbuf_pipe_chk #(.W(W), .NSTAGE(NSTAGE)) u_chk (
  .clk  (clk),
  .rst_n(rst_n),
  .bnd_t(bnd_t),
  .bnd_f(bnd_f),
  .ack_w(ack_w),
  .en_w (en_w)
);

// File: tb/hbuf_pipe_tb_top.sv
module hbuf_pipe_tb_top;
  localparam int         CLK_PERIOD = 10;
  localparam int         W          = 32;
  localparam int         NST        = 3;
  localparam logic [3:0] MASK       = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [W-1:0] c_in_t = '0, c_in_f = '0, c_out_t, c_out_f;
  logic         c_in_ack, c_out_ack = 1'b0;
  logic [W-1:0] s_in_t = '0, s_in_f = '0, s_out_t, s_out_f;
  logic         s_in_ack, s_out_ack = 1'b0;

  hbuf_pipe #(.W(W), .NSTAGE(NST), .INV_MASK(MASK)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_t(c_in_t), .in_f(c_in_f), .in_ack(c_in_ack),
    .out_t(c_out_t), .out_f(c_out_f), .out_ack(c_out_ack));

  hbuf_pipe #(.W(W), .NSTAGE(1), .INV_MASK(MASK)) single_i (
    .clk(clk), .rst_n(rst_n), .in_t(s_in_t), .in_f(s_in_f), .in_ack(s_in_ack),
    .out_t(s_out_t), .out_f(s_out_f), .out_ack(s_out_ack));

  int n_checks = 0;
  int n_fail   = 0;

  logic [W-1:0] src_q [$];
  logic [W-1:0] exp_q [$];
  int           t_valid [$];
  int           t_neut  [$];
  int           t_afall [$];
  bit           src_busy = 1'b0;
  bit           sink_ack = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R3: a masked slice flips once per stage, so it ends inverted for an odd count
  function automatic logic [W-1:0] expect_word(input logic [W-1:0] d, input int nst);
    logic [W-1:0] r = d;
    for (int k = 0; k < nst; k++)
      for (int s = 0; s < 4; s++)
        if (MASK[s]) r[s*8 +: 8] = ~r[s*8 +: 8];
    return r;
  endfunction

  function automatic logic [W-1:0] rd_t(input int which);
    return (which == 0) ? c_out_t : s_out_t;
  endfunction
  function automatic logic [W-1:0] rd_f(input int which);
    return (which == 0) ? c_out_f : s_out_f;
  endfunction
  function automatic logic rd_ack(input int which);
    return (which == 0) ? c_in_ack : s_in_ack;
  endfunction

  task automatic drive_in(input int which, input logic [W-1:0] t, input logic [W-1:0] f);
    if (which == 0) begin c_in_t = t; c_in_f = f; end
    else            begin s_in_t = t; s_in_f = f; end
  endtask

  task automatic set_ack(input int which, input logic v);
    sink_ack = v;
    if (which == 0) c_out_ack = v; else s_out_ack = v;
  endtask

  // producer and consumer, each answering one cycle after what it sees
  task automatic run_stream(input int which, input string req, input int max_cyc);
    bit prev_ack = rd_ack(which);
    for (int c = 0; c < max_cyc; c++) begin
      logic [W-1:0] ot, of, ex, d;
      bit full, empty, ack_now;
      @(negedge clk);
      ot = rd_t(which); of = rd_f(which);
      full = &(ot | of); empty = ~|(ot | of);
      ack_now = rd_ack(which);
      if (prev_ack && !ack_now) t_afall.push_back(cyc);
      prev_ack = ack_now;
      if (full && !sink_ack) begin
        if (exp_q.size() == 0) check(1'b0, req, "unexpected word", ot, '0);
        else begin
          ex = exp_q.pop_front();
          check(ot == ex && of == ~ex, req, "word value", ot, ex);
        end
        t_valid.push_back(cyc);
        set_ack(which, 1'b1);
      end else if (empty && sink_ack) begin
        t_neut.push_back(cyc);
        set_ack(which, 1'b0);
      end
      if (!src_busy && !ack_now && src_q.size() > 0) begin
        d = src_q.pop_front();
        drive_in(which, d, ~d);
        exp_q.push_back(expect_word(d, (which == 0) ? NST : 1));
        src_busy = 1'b1;
      end else if (src_busy && ack_now) begin
        drive_in(which, '0, '0);
        src_busy = 1'b0;
      end
      if (src_q.size() == 0 && !src_busy && exp_q.size() == 0 && empty && !sink_ack && !ack_now)
        return;
    end
    check(1'b0, req, "stream did not drain", exp_q.size(), 0);
  endtask

  task automatic test_reset;
    check(c_out_t == '0 && c_out_f == '0, "R1", "chain rails after reset", c_out_t | c_out_f, '0);
    check(c_in_ack == 1'b0, "R1", "chain in_ack after reset", c_in_ack, 0);
    check(s_out_t == '0 && s_out_f == '0, "R1", "single rails after reset", s_out_t | s_out_f, '0);
    check(s_in_ack == 1'b0, "R1", "single in_ack after reset", s_in_ack, 0);
  endtask

  task automatic test_latency;
    logic [W-1:0] d = 32'h5A3C_96E1;
    logic [W-1:0] ex = expect_word(d, NST);
    drive_in(0, d, ~d);
    exp_q.push_back(ex);
    src_busy = 1'b1;
    for (int c = 1; c <= 2*NST; c++) begin
      @(negedge clk);
      if (c == 2*NST-1)
        check((c_out_t | c_out_f) == '0, "R4", "output empty one edge early", c_out_t | c_out_f, '0);
      if (c == 2*NST) begin
        check(&(c_out_t | c_out_f), "R4", "output valid at 2*NSTAGE", c_out_t | c_out_f, '1);
        check(c_out_t == ex && c_out_f == ~ex, "R3", "slice mapping", c_out_t, ex);
      end
    end
    run_stream(0, "R3", 200);
  endtask

  task automatic test_partial;
    logic [W-1:0] d = 32'hC0FF_EE42;
    logic [W-1:0] ex = expect_word(d, NST);
    logic [W-1:0] lo = 32'h00FF_FFFF;
    drive_in(0, d & lo, ~d & lo);
    repeat (20) @(negedge clk);
    check(c_in_ack == 1'b0, "R5", "partial word acknowledged", c_in_ack, 0);
    check((c_out_t & lo) == (ex & lo) && (c_out_f & lo) == (~ex & lo), "R5",
          "complete slices pass", c_out_t & lo, ex & lo);
    check((c_out_t | c_out_f) >> 24 == '0, "R5", "missing slice stays empty",
          (c_out_t | c_out_f) >> 24, '0);
    drive_in(0, d, ~d);
    exp_q.push_back(ex);
    src_busy = 1'b1;
    run_stream(0, "R5", 200);
  endtask

  task automatic test_stall;
    logic [W-1:0] d = 32'h1357_9BDF;
    logic [W-1:0] ex = expect_word(d, NST);
    logic [W-1:0] snap;
    drive_in(0, d, ~d);
    exp_q.push_back(ex);
    src_busy = 1'b1;
    repeat (30) @(negedge clk);
    snap = c_out_t;
    check(c_out_t == ex && c_out_f == ~ex, "R6", "stalled output value", c_out_t, ex);
    check(c_in_ack == 1'b1, "R6", "input acknowledged while stalled", c_in_ack, 1);
    repeat (7) @(negedge clk);
    check(c_out_t == snap && c_out_f == ~snap, "R6", "stalled output stable", c_out_t, snap);
    run_stream(0, "R6", 200);
  endtask

  task automatic test_stream;
    for (int i = 0; i < 8; i++)
      src_q.push_back((32'h0F1E_2D3C * (i + 1)) ^ (32'h8421_0000 >> i));
    src_q.push_back('0);
    src_q.push_back('1);
    run_stream(0, "R8", 2000);
  endtask

  task automatic test_period;
    t_valid.delete(); t_neut.delete(); t_afall.delete();
    for (int i = 0; i < 4; i++) src_q.push_back(32'hA5A5_0000 + i);
    run_stream(1, "R8", 400);
    for (int i = 1; i < 4; i++)
      check(t_valid.size() > i && t_valid[i] - t_valid[i-1] == 10, "R9", "token spacing",
            (t_valid.size() > i) ? t_valid[i] - t_valid[i-1] : -1, 10);
    check(t_neut.size() > 0 && t_valid.size() > 0 && t_neut[0] - t_valid[0] == 5, "R7",
          "valid to empty", (t_neut.size() > 0) ? t_neut[0] - t_valid[0] : -1, 5);
    check(t_afall.size() > 0 && t_neut.size() > 0 && t_afall[0] - t_neut[0] == 2, "R7",
          "empty to ack fall", (t_afall.size() > 0) ? t_afall[0] - t_neut[0] : -1, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not end, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_latency();
    test_partial();
    test_stall();
    test_stream();
    test_period();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule